// File: doc/BRIEF.md
# GPIO Controller with Edge-Capture Interrupts

This block is a general-purpose I/O controller for 32 pins, reached through a plain 32-bit register bus with word offsets. For each pin, software chooses between input and output, and for outputs between push-pull and open-drain drive. Software sets the output level through a data register, and the same register reads back the pin state. The block does not instantiate the pad cells. It gives each pin an output-enable and an output-value signal, and it takes one raw pad level per pin.

Every pad level passes through a two-flop synchronizer. An edge detector then compares each synchronized sample with the one before it. Each pin has a control bit that selects which edges count: falling edges only, or both rising and falling. A detected edge sets a sticky event bit, whether or not the pin is masked. Software clears an event bit by writing a one to it. One combined interrupt output is high while any event bit is set on a pin whose mask bit is 1.

Register bits run opposite to pin numbers: pin n sits at bit 31−n, so pin 0 is the most significant bit. Reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, every output-enable is 0, and the interrupt output is 0.
- R2: The word offsets are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge-control 0x14. In every register, pin n uses bit 31−n.
- R3: A direction bit of 1 makes its pin an output. In push-pull mode, output-enable is 1 and the output value equals the data bit. A direction bit of 0 keeps output-enable at 0.
- R4: An output pin with its open-drain bit set has output-enable equal to the inverse of its data bit. Its output value is always 0.
- R5: A data-register read returns the written data bit for output pins and the synchronized pad level for input pins. A pad change driven before clock edge k shows up in the read after edge k+1.
- R6: An edge-control bit of 0 captures both rising and falling edges. A bit of 1 captures falling edges only, so a rising edge leaves the event bit at 0.
- R7: An edge on a pad driven before clock edge k sets the event bit at edge k+2, and not earlier.
- R8: Writing a 1 to an event bit clears it. Writing a 0 leaves it unchanged. Without such a write, a set event bit stays set.
- R9: Events are captured whatever the mask bit holds. The interrupt output is 1 exactly when some pin has both its event bit and its mask bit at 1.
- R10: If a new edge and a write-one-to-clear reach the same event bit in the same cycle, the bit stays set.
- R11: Offsets 0x18 and above, and addresses that are not word-aligned, read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| pad_in | input | PIN_COUNT (32) | Raw pad levels, index = pin number |
| pad_oe | output | PIN_COUNT (32) | Per-pin output enable, index = pin number |
| pad_out | output | PIN_COUNT (32) | Per-pin output value, index = pin number |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bound checker checks four rules on every clock cycle. An event bit never drops unless a write-one-to-clear reached it. Input pins and open-drain pins never drive high. The interrupt output stays low when every mask bit is 0 or no event is pending. The directed scenarios cover the rules that depend on exact timing and configuration: the edge-k+1 readback latency and the edge-k+2 event latency, falling-only versus both-edge selection, the reversed bit order, the same-cycle edge-and-clear collision, and accesses to unmapped or misaligned addresses.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   localparam int NUM_REGS = 6;
   localparam int NUM_CFG  = 5;

   // word index of each register (byte offset / 4)
   typedef enum int unsigned {
      REG_DIR = 0,
      REG_ODR = 1,
      REG_DAT = 2,
      REG_EVT = 3,
      REG_MSK = 4,
      REG_CTL = 5
   } reg_id_e;

   // slots inside the configuration store
   localparam int CFG_DIR = 0;
   localparam int CFG_ODR = 1;
   localparam int CFG_DAT = 2;
   localparam int CFG_MSK = 3;
   localparam int CFG_CTL = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= din;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
   parameter int PIN_COUNT = 32,
   parameter int NUM_CFG   = 5
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_CFG-1:0]                  wr_en,
   input  logic [PIN_COUNT-1:0]                wr_pin,
   output logic [NUM_CFG-1:0][PIN_COUNT-1:0]   cfg
);
   for (genvar r = 0; r < NUM_CFG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg[r] <= '0;
         end else if (wr_en[r]) begin
            cfg[r] <= wr_pin;
         end
      end
   end
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,          // synchronized pad level
   input  logic fall_only,    // 1: falling edges only, 0: both edges
   input  logic clr,          // write-one-to-clear strobe for this pin
   output logic evt
);
   logic prev_q;
   logic rise_w, fall_w, hit_w;

   assign rise_w = lvl & ~prev_q;
   assign fall_w = ~lvl & prev_q;
   assign hit_w  = fall_only ? fall_w : (rise_w | fall_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         evt    <= 1'b0;
      end else begin
         prev_q <= lvl;
         // a fresh edge wins over a clear in the same cycle
         evt    <= hit_w | (evt & ~clr);
      end
   end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int PIN_COUNT   = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_oe,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic                 irq
);
   localparam int IDX_W = ADDR_W - 2;

   if (PIN_COUNT < 1 || PIN_COUNT > DATA_W) begin : g_bad_pins
      $error("gpio_edge_ctrl: PIN_COUNT must lie in 1..DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_edge_ctrl: ADDR_W must reach offset 0x14");
   end

   // ---------------- address decode ----------------
   logic [IDX_W-1:0]     word_idx;
   logic                 aligned;
   logic [NUM_REGS-1:0]  wr_sel;
   logic [PIN_COUNT-1:0] wr_pin;

   assign word_idx = bus_addr[ADDR_W-1:2];
   assign aligned  = (bus_addr[1:0] == 2'b00);

   always_comb begin
      for (int r = 0; r < NUM_REGS; r++) begin
         wr_sel[r] = bus_wr && aligned && (int'(word_idx) == r);
      end
   end

   // register bit (DATA_W-1-n) belongs to pin n
   always_comb begin
      for (int n = 0; n < PIN_COUNT; n++) begin
         wr_pin[n] = bus_wdata[DATA_W-1-n];
      end
   end

   // ---------------- configuration store ----------------
   logic [NUM_CFG-1:0]                cfg_wr;
   logic [NUM_CFG-1:0][PIN_COUNT-1:0] cfg;

   assign cfg_wr[CFG_DIR] = wr_sel[REG_DIR];
   assign cfg_wr[CFG_ODR] = wr_sel[REG_ODR];
   assign cfg_wr[CFG_DAT] = wr_sel[REG_DAT];
   assign cfg_wr[CFG_MSK] = wr_sel[REG_MSK];
   assign cfg_wr[CFG_CTL] = wr_sel[REG_CTL];

   gpio_cfg_regs #(.PIN_COUNT(PIN_COUNT), .NUM_CFG(NUM_CFG)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr),
      .wr_pin (wr_pin),
      .cfg    (cfg)
   );

   logic [PIN_COUNT-1:0] dir_pin, odr_pin, dat_pin, msk_pin, ctl_pin;
   assign dir_pin = cfg[CFG_DIR];
   assign odr_pin = cfg[CFG_ODR];
   assign dat_pin = cfg[CFG_DAT];
   assign msk_pin = cfg[CFG_MSK];
   assign ctl_pin = cfg[CFG_CTL];

   // ---------------- input path ----------------
   logic [PIN_COUNT-1:0] lvl_pin;

   gpio_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (lvl_pin)
   );

   logic [PIN_COUNT-1:0] evt_pin;
   logic [PIN_COUNT-1:0] clr_pin;

   assign clr_pin = wr_sel[REG_EVT] ? wr_pin : '0;

   for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
      gpio_edge_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .lvl       (lvl_pin[n]),
         .fall_only (ctl_pin[n]),
         .clr       (clr_pin[n]),
         .evt       (evt_pin[n])
      );
   end

   // ---------------- output drive ----------------
   for (genvar n = 0; n < PIN_COUNT; n++) begin : g_drive
      assign pad_oe[n]  = dir_pin[n] & (odr_pin[n] ? ~dat_pin[n] : 1'b1);
      assign pad_out[n] = dat_pin[n] & ~odr_pin[n];
   end

   assign irq = |(evt_pin & msk_pin);

   // ---------------- read path ----------------
   logic [PIN_COUNT-1:0] rd_pin;
   logic [PIN_COUNT-1:0] dat_view;

   assign dat_view = (dir_pin & dat_pin) | (~dir_pin & lvl_pin);

   always_comb begin
      rd_pin = '0;
      if (aligned) begin
         case (int'(word_idx))
            REG_DIR: rd_pin = dir_pin;
            REG_ODR: rd_pin = odr_pin;
            REG_DAT: rd_pin = dat_view;
            REG_EVT: rd_pin = evt_pin;
            REG_MSK: rd_pin = msk_pin;
            REG_CTL: rd_pin = ctl_pin;
            default: rd_pin = '0;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int n = 0; n < PIN_COUNT; n++) begin
         bus_rdata[DATA_W-1-n] = rd_pin[n];
      end
   end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
   parameter int PIN_COUNT = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [PIN_COUNT-1:0] pad_oe,
   input logic [PIN_COUNT-1:0] pad_out,
   input logic                 irq,
   input logic [PIN_COUNT-1:0] dir_pin,
   input logic [PIN_COUNT-1:0] odr_pin,
   input logic [PIN_COUNT-1:0] evt_pin,
   input logic [PIN_COUNT-1:0] msk_pin
);
   logic [PIN_COUNT-1:0] clr_now, evt_q, clr_q;

   always_comb begin
      clr_now = '0;
      if (bus_wr && bus_addr == ADDR_W'(12)) begin
         for (int n = 0; n < PIN_COUNT; n++) clr_now[n] = bus_wdata[DATA_W-1-n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= '0;
         clr_q <= '0;
      end else begin
         evt_q <= evt_pin;
         clr_q <= clr_now;
      end
   end

   // R8: a pending event only drops where a one was written to it
   a_r8_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_q & ~evt_pin & ~clr_q) == '0));

   // R3: input pins never enable their driver
   a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~dir_pin) == '0));

   // R4: open-drain pins never present a high value
   a_r4_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & odr_pin) == '0));

   // R9: nothing unmasked means no interrupt
   a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_pin == '0) |-> !irq);

   // R9: interrupt implies a pending event
   a_r9_irq_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt_pin != '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
   .PIN_COUNT (PIN_COUNT),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .irq       (irq),
   .dir_pin   (dir_pin),
   .odr_pin   (odr_pin),
   .evt_pin   (evt_pin),
   .msk_pin   (msk_pin)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb_top;
   localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08,
                          A_EVT = 5'h0C, A_MSK = 5'h10, A_CTL = 5'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe, pad_out;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_edge_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
   );

   function automatic logic [31:0] pbit(int n);
      return 32'h8000_0000 >> n;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(logic [4:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(A_DIR, v); chk("R1 dir", v, 0);
      rd(A_ODR, v); chk("R1 odr", v, 0);
      rd(A_DAT, v); chk("R1 dat", v, 0);
      rd(A_EVT, v); chk("R1 evt", v, 0);
      rd(A_MSK, v); chk("R1 msk", v, 0);
      rd(A_CTL, v); chk("R1 ctl", v, 0);
      chk("R1 oe", pad_oe, 0);
      chk("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_direction;
      logic [31:0] v;
      wr(A_DIR, pbit(0) | pbit(31));
      wr(A_DAT, pbit(0));
      chk("R3 oe pins 0/31", pad_oe, 32'h8000_0001);
      chk("R3 out pin0 high", pad_out, 32'h0000_0001);
      rd(A_DAT, v); chk("R2 pin0 at msb", v, 32'h8000_0000);
      rd(A_DIR, v); chk("R2 dir readback", v, 32'h8000_0001);
   endtask

   task automatic t_open_drain;
      wr(A_DIR, pbit(2));
      wr(A_ODR, pbit(2));
      wr(A_DAT, pbit(2));
      chk("R4 od high releases", pad_oe, 0);
      chk("R4 od out low", pad_out, 0);
      wr(A_DAT, 0);
      chk("R4 od low drives", pad_oe, 32'h0000_0004);
      chk("R4 od out still low", pad_out, 0);
      wr(A_ODR, 0);
      wr(A_DIR, 0);
   endtask

   task automatic t_readback;
      logic [31:0] v;
      wr(A_DIR, pbit(0));
      wr(A_DAT, pbit(0));
      pad_in[10] = 1'b1;
      idle(1);
      rd(A_DAT, v); chk("R5 not yet synced", v, pbit(0));
      idle(1);
      rd(A_DAT, v); chk("R5 input and driven mix", v, pbit(0) | pbit(10));
      pad_in[0] = 1'b0;
      idle(3);
      rd(A_DAT, v); chk("R5 output ignores pad", v & pbit(0), pbit(0));
      pad_in[10] = 1'b0;
      wr(A_DIR, 0);
      wr(A_DAT, 0);
      idle(4);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr(5'h18, 32'hFFFF_FFFF);
      wr(5'h1C, 32'hFFFF_FFFF);
      wr(5'h01, 32'hFFFF_FFFF);
      rd(5'h18, v); chk("R11 0x18 reads 0", v, 0);
      rd(5'h02, v); chk("R11 misaligned reads 0", v, 0);
      rd(A_DIR, v); chk("R11 dir untouched", v, 0);
      rd(A_MSK, v); chk("R11 msk untouched", v, 0);
      rd(A_CTL, v); chk("R11 ctl untouched", v, 0);
      chk("R11 oe untouched", pad_oe, 0);
   endtask

   task automatic t_edge_modes;
      logic [31:0] v;
      wr(A_CTL, pbit(3));
      wr(A_EVT, 32'hFFFF_FFFF);
      rd(A_EVT, v); chk("R8 all-ones clears", v, 0);
      pad_in[3] = 1'b1; idle(4);
      rd(A_EVT, v); chk("R6 rising ignored when falling-only", v, 0);
      pad_in[3] = 1'b0; idle(4);
      rd(A_EVT, v); chk("R6 falling captured", v, pbit(3));
   endtask

   task automatic t_latency;
      logic [31:0] v;
      pad_in[4] = 1'b1;
      idle(2);
      rd(A_EVT, v); chk("R7 event not early", v & pbit(4), 0);
      idle(1);
      rd(A_EVT, v); chk("R7 rising captured at k+2", v & pbit(4), pbit(4));
   endtask

   task automatic t_w1c;
      logic [31:0] v;
      wr(A_EVT, 0);
      rd(A_EVT, v); chk("R8 zero write keeps", v, pbit(3) | pbit(4));
      wr(A_EVT, pbit(3));
      rd(A_EVT, v); chk("R8 clear single", v, pbit(4));
      wr(A_EVT, 32'hFFFF_FFFF);
      rd(A_EVT, v); chk("R8 clear all", v, 0);
   endtask

   task automatic t_mask;
      logic [31:0] v;
      pad_in[7] = 1'b1; idle(4);
      rd(A_EVT, v); chk("R9 captured while masked", v, pbit(7));
      chk("R9 masked no irq", {31'd0, irq}, 0);
      wr(A_MSK, pbit(7));
      chk("R9 unmask raises irq", {31'd0, irq}, 1);
      wr(A_MSK, pbit(8));
      chk("R9 other mask no irq", {31'd0, irq}, 0);
      wr(A_MSK, pbit(7));
      wr(A_EVT, pbit(7));
      chk("R9 clear drops irq", {31'd0, irq}, 0);
      wr(A_MSK, 0);
   endtask

   task automatic t_collision;
      logic [31:0] v;
      pad_in[5] = 1'b1; idle(4);
      rd(A_EVT, v); chk("R10 setup event", v, pbit(5));
      pad_in[5] = 1'b0;          // edge k follows
      idle(2);                   // edges k, k+1 passed
      wr(A_EVT, pbit(5));        // clear lands on edge k+2 with the event
      rd(A_EVT, v); chk("R10 edge beats clear", v, pbit(5));
      wr(A_EVT, pbit(5));
      rd(A_EVT, v); chk("R10 later clear works", v, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direction();
      wr(A_DIR, 0); wr(A_DAT, 0);
      t_open_drain();
      t_readback();
      t_unmapped();
      t_edge_modes();
      t_latency();
      t_w1c();
      t_mask();
      t_collision();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule